// File: doc/BRIEF.md
# Extended Audio Control and Sample-Rate Register Bank

This block keeps the extended audio control/status word and the two 16-bit sample-rate registers (playback converter and record converter) of a two-channel audio codec that follows the AC'97 register model. A host-side register port writes and reads them. The port carries a 7-bit address, 16-bit write data, a write strobe and a combinational read-data bus. The block sends its live settings to the rest of the codec: variable-rate enable, S/PDIF output enable, the validity-override flag, the S/PDIF slot-assignment code and both rates.

Two board inputs are sampled while reset is held. One is a strap that removes the S/PDIF function. The other is a 2-bit codec identifier that picks the default slot assignment. A status input from the S/PDIF transmitter shows whether its configuration is valid, and that status appears in the control word. Rate writes are rounded to the nearest rate the converters support. Turning variable-rate mode off pins both rates at 48 kHz. The block also drives a permit line for the separate S/PDIF control register, which may only be rewritten while S/PDIF is switched off.

Top module: `ext_audio_regs`

## Requirements
- R1: During and straight after a synchronous active-low reset, `vra_en`, `spdif_en` and `vcfg` are 0, and both rates read BB80h.
- R2: While reset is held, `codec_id` sets the slot code (bits 5:4 of the control word at 2Ah), as follows: ID 0 gives 1, ID 1 gives 2, ID 2 gives 2, and ID 3 gives 3.
- R3: A write to 2Ah stores bit 15 (validity override), bits 5:4 (slot code), bit 2 (S/PDIF enable) and bit 0 (variable-rate enable). Bit 10 reads the `spdif_cfg_ok` input. All other bits read 0.
- R4: If `spdif_off_strap` is high while reset is held, then until the next reset bits 15:1 of 2Ah read 0 and ignore writes, and `spdif_en`, `vcfg` and `slot_code` stay 0. Bit 0 stays writable.
- R5: A rate write (2Ch for playback, 32h for record) of a supported value reads back unchanged. The supported values are 1F40h, 2B11h, 3E80h, 5622h, 7D00h, AC44h and BB80h.
- R6: Any other rate write stores the nearest supported value. On a tie the higher value is stored. Values below 1F40h give 1F40h and values above BB80h give BB80h.
- R7: In the cycle after any cycle in which `vra_en` is 0, both rates equal BB80h, and rate writes made during such a cycle have no effect.
- R8: A write to one rate register never changes the other.
- R9: `spdif_ctl_wr_ok` is high exactly when the S/PDIF enable bit is 0.
- R10: A read of any address other than 2Ah, 2Ch and 32h returns 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 7 | Register address for writes and reads |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| spdif_off_strap | input | 1 | Strap that removes S/PDIF, sampled during reset |
| codec_id | input | 2 | Codec identifier, sampled during reset |
| spdif_cfg_ok | input | 1 | S/PDIF configuration-valid status |
| vra_en | output | 1 | Variable-rate mode enabled |
| spdif_en | output | 1 | S/PDIF output enabled |
| vcfg | output | 1 | Validity-flag override |
| slot_code | output | 2 | S/PDIF slot-assignment code |
| dac_rate | output | 16 | Playback rate in Hz |
| adc_rate | output | 16 | Record rate in Hz |
| spdif_ctl_wr_ok | output | 1 | Permit to write the S/PDIF control register |

## Verification
The assertions check on every cycle that each stored rate is a member of the supported set and that rates are pinned at 48 kHz after a cycle with variable-rate mode off. They also check that a locked strap keeps the S/PDIF fields at zero, that reserved bits and unmapped addresses read zero, and that a write to one rate leaves the other unchanged. Only the bench scenarios can show that the rounding picks the correct neighbour, including the tie points and both clamps. The same applies to the codec-ID reset map across several resets and to the strap being captured during reset rather than watched live.

// File: rtl/ext_audio_pkg.sv
package ext_audio_pkg;
  localparam int AW = 7;
  localparam int DW = 16;
  localparam logic [AW-1:0] ADDR_CTL = 7'h2A;
  localparam logic [AW-1:0] ADDR_DAC = 7'h2C;
  localparam logic [AW-1:0] ADDR_ADC = 7'h32;
  localparam int RATE_N = 7;
  localparam logic [DW-1:0] RATE_TBL [RATE_N] = '{
    16'h1F40, 16'h2B11, 16'h3E80, 16'h5622, 16'h7D00, 16'hAC44, 16'hBB80
  };
  localparam logic [DW-1:0] RATE_DEFAULT = RATE_TBL[RATE_N-1];
  localparam logic [DW-1:0] CTL_RSVD_MASK = 16'h7BCA;

  // Nearest supported rate; ascending scan with <= makes ties pick the higher.
  function automatic logic [DW-1:0] snap_rate(input logic [DW-1:0] v);
    logic [DW-1:0] best;
    int unsigned best_d, d;
    best   = RATE_TBL[0];
    best_d = 32'hFFFF_FFFF;
    for (int i = 0; i < RATE_N; i++) begin
      d = (v > RATE_TBL[i]) ? 32'(v - RATE_TBL[i]) : 32'(RATE_TBL[i] - v);
      if (d <= best_d) begin
        best   = RATE_TBL[i];
        best_d = d;
      end
    end
    return best;
  endfunction

  function automatic logic is_supported(input logic [DW-1:0] v);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < RATE_N; i++) hit |= (v == RATE_TBL[i]);
    return hit;
  endfunction

  // Default slot code for each codec identifier.
  function automatic logic [1:0] slot_from_id(input logic [1:0] id);
    case (id)
      2'd0:    return 2'd1;
      2'd1:    return 2'd2;
      2'd2:    return 2'd2;
      default: return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/ext_ctl_word.sv
module ext_ctl_word
  import ext_audio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit,
  input  logic       w_vcfg,
  input  logic [1:0] w_slot,
  input  logic       w_spdif,
  input  logic       w_vra,
  input  logic       strap,
  input  logic [1:0] codec_id,
  output logic       lock_q,
  output logic       vcfg_q,
  output logic [1:0] slot_q,
  output logic       spdif_q,
  output logic       vra_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q  <= strap;
      slot_q  <= strap ? 2'd0 : slot_from_id(codec_id);
      vcfg_q  <= 1'b0;
      spdif_q <= 1'b0;
      vra_q   <= 1'b0;
    end else if (wr_hit) begin
      vra_q <= w_vra;
      if (!lock_q) begin
        vcfg_q  <= w_vcfg;
        slot_q  <= w_slot;
        spdif_q <= w_spdif;
      end
    end
  end
endmodule

// File: rtl/ext_rate_reg.sv
module ext_rate_reg
  import ext_audio_pkg::*;
#(
  parameter logic [AW-1:0] MY_ADDR = ADDR_DAC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          vra,
  output logic [DW-1:0] rate_q
);
  logic hit;
  assign hit = wr_en && (addr == MY_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n)      rate_q <= RATE_DEFAULT;
    else if (!vra)   rate_q <= RATE_DEFAULT;
    else if (hit)    rate_q <= snap_rate(wdata);
  end
endmodule

// File: rtl/ext_audio_regs.sv
module ext_audio_regs
  import ext_audio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          spdif_off_strap,
  input  logic [1:0]    codec_id,
  input  logic          spdif_cfg_ok,
  output logic          vra_en,
  output logic          spdif_en,
  output logic          vcfg,
  output logic [1:0]    slot_code,
  output logic [DW-1:0] dac_rate,
  output logic [DW-1:0] adc_rate,
  output logic          spdif_ctl_wr_ok
);
  logic          lock_q;
  logic          ctl_hit;
  logic [DW-1:0] ctl_word;

  assign ctl_hit = wr_en && (addr == ADDR_CTL);

  ext_ctl_word u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_hit   (ctl_hit),
    .w_vcfg   (wdata[15]),
    .w_slot   (wdata[5:4]),
    .w_spdif  (wdata[2]),
    .w_vra    (wdata[0]),
    .strap    (spdif_off_strap),
    .codec_id (codec_id),
    .lock_q   (lock_q),
    .vcfg_q   (vcfg),
    .slot_q   (slot_code),
    .spdif_q  (spdif_en),
    .vra_q    (vra_en)
  );

  ext_rate_reg #(.MY_ADDR(ADDR_DAC)) u_dac (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .vra(vra_en), .rate_q(dac_rate)
  );

  ext_rate_reg #(.MY_ADDR(ADDR_ADC)) u_adc (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .vra(vra_en), .rate_q(adc_rate)
  );

  always_comb begin
    ctl_word     = '0;
    ctl_word[15] = vcfg;
    ctl_word[10] = spdif_cfg_ok && !lock_q;
    ctl_word[5:4] = slot_code;
    ctl_word[2]  = spdif_en;
    ctl_word[0]  = vra_en;
  end

  always_comb begin
    case (addr)
      ADDR_CTL: rdata = ctl_word;
      ADDR_DAC: rdata = dac_rate;
      ADDR_ADC: rdata = adc_rate;
      default:  rdata = '0;
    endcase
  end

  assign spdif_ctl_wr_ok = !spdif_en;
endmodule

// File: rtl/ext_audio_regs_chk.sv
module ext_audio_regs_chk
  import ext_audio_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] rdata,
  input logic          lock_q,
  input logic          vra_en,
  input logic          spdif_en,
  input logic          vcfg,
  input logic [1:0]    slot_code,
  input logic [DW-1:0] dac_rate,
  input logic [DW-1:0] adc_rate
);
  a_r7_pinned_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !vra_en |=> (dac_rate == RATE_DEFAULT) && (adc_rate == RATE_DEFAULT));

  a_r6_dac_in_set: assert property (@(posedge clk) disable iff (!rst_n)
    is_supported(dac_rate));

  a_r6_adc_in_set: assert property (@(posedge clk) disable iff (!rst_n)
    is_supported(adc_rate));

  a_r8_dac_leaves_adc: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_DAC && vra_en) |=> $stable(adc_rate));

  a_r8_adc_leaves_dac: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_ADC && vra_en) |=> $stable(dac_rate));

  a_r4_locked_fields: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> (!spdif_en && !vcfg && slot_code == 2'd0));

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_CTL) |-> ((rdata & CTL_RSVD_MASK) == '0));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != ADDR_CTL && addr != ADDR_DAC && addr != ADDR_ADC) |-> (rdata == '0));
endmodule

bind ext_audio_regs ext_audio_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .rdata(rdata),
  .lock_q(lock_q), .vra_en(vra_en), .spdif_en(spdif_en), .vcfg(vcfg),
  .slot_code(slot_code), .dac_rate(dac_rate), .adc_rate(adc_rate)
);

// File: tb/ext_audio_regs_tb.sv
module ext_audio_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        spdif_off_strap = 1'b0;
  logic [1:0]  codec_id = '0;
  logic        spdif_cfg_ok = 1'b0;
  logic        vra_en, spdif_en, vcfg, spdif_ctl_wr_ok;
  logic [1:0]  slot_code;
  logic [15:0] dac_rate, adc_rate;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [6:0]  a;
    logic [15:0] exp;
    string       tag;
  } sb_item_t;
  sb_item_t sb[$];

  always #10 clk = ~clk;

  ext_audio_regs u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .spdif_off_strap(spdif_off_strap), .codec_id(codec_id),
    .spdif_cfg_ok(spdif_cfg_ok), .vra_en(vra_en), .spdif_en(spdif_en),
    .vcfg(vcfg), .slot_code(slot_code), .dac_rate(dac_rate),
    .adc_rate(adc_rate), .spdif_ctl_wr_ok(spdif_ctl_wr_ok)
  );

  // Monitor: pops expected read items and compares away from the active edge.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      sb_item_t it;
      it = sb.pop_front();
      checks++;
      if (rdata !== it.exp) begin
        errors++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.a, rdata, it.exp);
      end
    end
  end

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap, input logic [1:0] id);
    @(posedge clk); #1;
    rst_n = 1'b0; spdif_off_strap = strap; codec_id = id;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [15:0] exp, input string tag);
    sb_item_t it;
    @(posedge clk); #1;
    addr = a;
    it.a = a; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R2: slot code per codec ID, and R1 reset state
    for (int id = 0; id < 4; id++) begin
      logic [1:0] es;
      es = (id == 0) ? 2'd1 : (id == 3) ? 2'd3 : 2'd2;
      do_reset(1'b0, 2'(id));
      rd(7'h2A, {10'd0, es, 4'd0}, "R2 slot from id");
    end
    chk({15'd0, vra_en}, 16'h0000, "R1 vra_en at reset");
    chk({15'd0, spdif_en}, 16'h0000, "R1 spdif_en at reset");
    chk(dac_rate, 16'hBB80, "R1 dac_rate at reset");
    rd(7'h32, 16'hBB80, "R1 adc read at reset");

    do_reset(1'b0, 2'd0);
    spdif_cfg_ok = 1'b1;
    // R3 field write and readback
    wr(7'h2A, 16'hFFFF);
    rd(7'h2A, 16'h8435, "R3 all fields set");
    chk({14'd0, slot_code}, 16'h0003, "R3 slot_code port");
    chk({15'd0, spdif_ctl_wr_ok}, 16'h0000, "R9 permit low when enabled");
    wr(7'h2A, 16'h0000);
    rd(7'h2A, 16'h0400, "R3 cleared, status bit only");
    chk({15'd0, spdif_ctl_wr_ok}, 16'h0001, "R9 permit high when disabled");

    wr(7'h2A, 16'h0001);
    // R5 supported echo, R8 independence
    wr(7'h2C, 16'h2B11);
    rd(7'h2C, 16'h2B11, "R5 supported echo");
    rd(7'h32, 16'hBB80, "R8 adc untouched");
    // R6 rounding
    wr(7'h2C, 16'h4A51); rd(7'h2C, 16'h5622, "R6 tie 19025 goes up");
    wr(7'h2C, 16'hB3E1); rd(7'h2C, 16'hAC44, "R6 46049 goes down");
    wr(7'h2C, 16'hB3E2); rd(7'h2C, 16'hBB80, "R6 tie 46050 goes up");
    wr(7'h2C, 16'hEA60); rd(7'h2C, 16'hBB80, "R6 clamp high");
    wr(7'h2C, 16'h2528); rd(7'h2C, 16'h1F40, "R6 9512 goes down");
    wr(7'h2C, 16'h2529); rd(7'h2C, 16'h2B11, "R6 9513 goes up");
    wr(7'h2C, 16'h0064); rd(7'h2C, 16'h1F40, "R6 clamp low");
    wr(7'h32, 16'h7D00);
    rd(7'h32, 16'h7D00, "R5 adc echo");
    rd(7'h2C, 16'h1F40, "R8 dac untouched");
    // R7 clearing variable-rate mode
    wr(7'h2A, 16'h0000);
    rd(7'h2C, 16'hBB80, "R7 dac forced");
    rd(7'h32, 16'hBB80, "R7 adc forced");
    wr(7'h2C, 16'h3E80);
    rd(7'h2C, 16'hBB80, "R7 write ignored");
    // R10 unmapped
    rd(7'h00, 16'h0000, "R10 addr 00");
    rd(7'h2E, 16'h0000, "R10 addr 2E");
    rd(7'h7F, 16'h0000, "R10 addr 7F");

    // R4 strap lock
    do_reset(1'b1, 2'd3);
    spdif_cfg_ok = 1'b1;
    rd(7'h2A, 16'h0000, "R4 locked reads zero");
    wr(7'h2A, 16'hFFFF);
    rd(7'h2A, 16'h0001, "R4 only bit 0 writable");
    chk({15'd0, spdif_en}, 16'h0000, "R4 spdif_en stays low");
    spdif_off_strap = 1'b0;
    wr(7'h2A, 16'hFFFF);
    rd(7'h2A, 16'h0001, "R4 strap not watched after reset");
    wr(7'h2C, 16'hAC44);
    rd(7'h2C, 16'hAC44, "R4 rates usable when locked");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule